// File: doc/BRIEF.md
# DRAM Training Command Sequencer

This block is a per-channel engine that sends batches of DRAM commands while memory is being trained. Software sets up to four sub-sequences through a small register port. Each sub-sequence names one command: an opcode, an address and a data direction. It also sets how many times that command repeats, how many clock cycles separate the repeats, and how long the engine stays quiet before the next sub-sequence starts.

A sequence register holds the rest of the setup:
- the index of the last sub-sequence to run,
- how many times the whole sequence repeats,
- a rest period after each full pass,
- a stop-on-error switch,
- an enable for an error trigger output.

Writing a non-zero repeat count starts the run at once. The value 255 means "repeat forever", and writing zero aborts the run.

Each issued command shows up as a one-cycle valid strobe, together with the sub-sequence index and that sub-sequence's command fields. An error input from an external data checker can halt the run. The same input can also raise a sticky trigger. Address stepping, data comparison and refresh live in neighbouring blocks.

Top module: `train_cmd_seq`

## Requirements
- R1: After reset the block is idle (idle=1, busy, done, error and trigger all 0), cmdValid is 0, and every register reads back as zero.
- R2: A write to the sequence register (address 8) whose repeat field (bits [15:8]) is non-zero, made while idle, starts a run. In the cycle after the write edge, cmdValid=1 with cmdSubIdx=0, and the done, error and trigger flags read 0.
- R3: Sub-sequence i issues its command N times, where N is the repeat field in bits [8:0] of register 4+i. A field of 0 issues the command once. Every issue is a cycle with cmdValid=1, cmdSubIdx=i, and the address, opcode and direction taken from register i: bits [15:0], [18:16] and [21:20], with direction 00 none, 01 read, 10 write, 11 read and write.
- R4: Two successive issues of one sub-sequence are G+1 cycles apart, where G is bits [22:18] of register 4+i.
- R5: The first issue of the next sub-sequence comes D+1 cycles after the last issue of sub-sequence i, where D is bits [17:9] of register 4+i.
- R6: Sub-sequences run in ascending order from 0 up to and including the last-index field (bits [1:0] of register 8). Higher sub-sequences never issue.
- R7: After each full pass the engine rests for W cycles (bits [24:16] of register 8), so the next pass begins W+1 cycles after the last issue of the pass. The repeat field decrements by one at the end of each pass and reads back at bits [15:8].
- R8: When the count runs out, the block returns to idle with done=1. Done stays set until the next start.
- R9: A repeat field of 255 is never decremented. Writing 0 to it aborts a run: from the next cycle the block is idle, issues nothing, and done stays 0.
- R10: With stop-on-error set (bit 2 of register 8), an errIn cycle while busy halts the run. From the next cycle the block is idle with error=1 and issues nothing more.
- R11: With the trigger enable set (bit 3 of register 8), the first errIn cycle while busy sets a sticky trigger. Without stop-on-error, the run continues to completion.
- R12: Register 9 reads the status as idle [0], busy [1], done [2], error [3], trigger [4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 4 | Register address for write and read |
| cfgWrData | input | 32 | Register write data |
| cfgRdData | output | 32 | Register read data for cfgAddr |
| errIn | input | 1 | Error indication from the data checker |
| cmdValid | output | 1 | One command issued this cycle |
| cmdSubIdx | output | 2 | Sub-sequence that issued the command |
| cmdCode | output | 3 | Command opcode bits |
| cmdAddr | output | 16 | Base command address of the sub-sequence |
| cmdDir | output | 2 | Data direction of the command |
| seqIdle | output | 1 | Engine idle |
| seqBusy | output | 1 | Engine running |
| seqDone | output | 1 | Last run completed |
| seqError | output | 1 | Last run halted on an error |
| errTrigger | output | 1 | Sticky first-error trigger |

## Verification
The hardest states to reach from the ports are the ones where control changes hands in the middle of timed waiting. Two examples are an error that lands during an inter-command gap under stop-on-error, and an abort of an endless run. To reach them, the stimulus first starts long runs (many repeats with wide gaps, or the endless count), then drives errIn or a zero repeat count in a cycle chosen by counting from the start. A behavioural cycle model in the bench follows every run and compares all outputs each clock. Separate checks measure the spacing between issues, the sub-sequence order, and the repeat count read back after each run.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int NUM_SUB = 4;
  localparam int SUB_W   = $clog2(NUM_SUB);
  localparam int REP_W   = 9;
  localparam int GAP_W   = 5;
  localparam int IDLE_W  = 9;
  localparam int WAIT_W  = 9;
  localparam int ITER_W  = 8;
  localparam int ADDR_W  = 16;
  localparam int CODE_W  = 3;
  localparam int DIR_W   = 2;
  localparam int DATA_W  = 32;
  localparam int REG_AW  = 4;
  localparam int TMR_A   = (IDLE_W > WAIT_W) ? IDLE_W : WAIT_W;
  localparam int TMR_W   = (TMR_A > GAP_W) ? TMR_A : GAP_W;

  // command register fields
  localparam int CODE_LSB = ADDR_W;
  localparam int DIR_LSB  = CODE_LSB + CODE_W + 1;
  // timing register fields
  localparam int IDLE_LSB = REP_W;
  localparam int GAP_LSB  = IDLE_LSB + IDLE_W;
  // sequence register fields
  localparam int LAST_LSB   = 0;
  localparam int STOP_BIT   = SUB_W;
  localparam int TRIGEN_BIT = SUB_W + 1;
  localparam int ITER_LSB   = 8;
  localparam int WAIT_LSB   = ITER_LSB + ITER_W;
  // register addresses
  localparam int CMD_BASE  = 0;
  localparam int TIM_BASE  = NUM_SUB;
  localparam int SEQ_ADDR  = 2 * NUM_SUB;
  localparam int STAT_ADDR = 2 * NUM_SUB + 1;
  localparam int STAT_W    = 5;

  typedef enum logic [2:0] {ST_IDLE, ST_ISSUE, ST_GAP, ST_POST, ST_WAIT} seq_state_t;

  typedef struct packed {
    logic clrSub;
    logic incSub;
    logic clrRep;
    logic incRep;
    logic loadGap;
    logic loadIdle;
    logic loadWait;
    logic decTimer;
    logic decIter;
  } ctl_strobe_t;

  typedef struct packed {
    logic repLast;
    logic gapZero;
    logic idleZero;
    logic waitZero;
    logic timerOne;
    logic subLast;
    logic iterOne;
    logic iterZero;
    logic iterInf;
    logic startReq;
    logic abortReq;
    logic stopOnErr;
    logic trigEn;
  } dp_flag_t;
endpackage

// File: rtl/tcs_datapath.sv
module tcs_datapath
  import tcs_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [REG_AW-1:0]  cfgAddr,
  input  logic [DATA_W-1:0]  cfgWrData,
  output logic [DATA_W-1:0]  cfgRdData,
  input  ctl_strobe_t        stb,
  input  logic [STAT_W-1:0]  statusBits,
  output dp_flag_t           flags,
  output logic [SUB_W-1:0]   subIdx,
  output logic [CODE_W-1:0]  cmdCode,
  output logic [ADDR_W-1:0]  cmdAddr,
  output logic [DIR_W-1:0]   cmdDir
);
  logic [ADDR_W-1:0] addrArr [NUM_SUB];
  logic [CODE_W-1:0] codeArr [NUM_SUB];
  logic [DIR_W-1:0]  dirArr  [NUM_SUB];
  logic [REP_W-1:0]  repsArr [NUM_SUB];
  logic [GAP_W-1:0]  gapArr  [NUM_SUB];
  logic [IDLE_W-1:0] idleArr [NUM_SUB];

  logic [SUB_W-1:0]  subQ;
  logic [REP_W-1:0]  repQ;
  logic [TMR_W-1:0]  tmrQ;
  logic [ITER_W-1:0] iterQ;
  logic [WAIT_W-1:0] waitQ;
  logic [SUB_W-1:0]  lastQ;
  logic              stopQ, trigEnQ;

  logic              wrSeq;
  logic [ITER_W-1:0] wrIter;
  logic [REP_W-1:0]  curReps, repLimit;

  assign wrSeq  = cfgWrEn && (cfgAddr == REG_AW'(SEQ_ADDR));
  assign wrIter = cfgWrData[ITER_LSB +: ITER_W];

  for (genvar i = 0; i < NUM_SUB; i++) begin : g_sub
    logic [ADDR_W-1:0] addrR;
    logic [CODE_W-1:0] codeR;
    logic [DIR_W-1:0]  dirR;
    logic [REP_W-1:0]  repsR;
    logic [GAP_W-1:0]  gapR;
    logic [IDLE_W-1:0] idleR;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        addrR <= '0; codeR <= '0; dirR <= '0;
        repsR <= '0; gapR <= '0; idleR <= '0;
      end else begin
        if (cfgWrEn && (cfgAddr == REG_AW'(CMD_BASE + i))) begin
          addrR <= cfgWrData[ADDR_W-1:0];
          codeR <= cfgWrData[CODE_LSB +: CODE_W];
          dirR  <= cfgWrData[DIR_LSB +: DIR_W];
        end
        if (cfgWrEn && (cfgAddr == REG_AW'(TIM_BASE + i))) begin
          repsR <= cfgWrData[REP_W-1:0];
          idleR <= cfgWrData[IDLE_LSB +: IDLE_W];
          gapR  <= cfgWrData[GAP_LSB +: GAP_W];
        end
      end
    end
    assign addrArr[i] = addrR;
    assign codeArr[i] = codeR;
    assign dirArr[i]  = dirR;
    assign repsArr[i] = repsR;
    assign gapArr[i]  = gapR;
    assign idleArr[i] = idleR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iterQ <= '0; waitQ <= '0; lastQ <= '0; stopQ <= 1'b0; trigEnQ <= 1'b0;
    end else begin
      if (wrSeq) begin
        iterQ   <= wrIter;
        waitQ   <= cfgWrData[WAIT_LSB +: WAIT_W];
        lastQ   <= cfgWrData[LAST_LSB +: SUB_W];
        stopQ   <= cfgWrData[STOP_BIT];
        trigEnQ <= cfgWrData[TRIGEN_BIT];
      end else if (stb.decIter && !flags.iterInf && !flags.iterZero) begin
        iterQ <= iterQ - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subQ <= '0; repQ <= '0; tmrQ <= '0;
    end else begin
      if (stb.clrSub)      subQ <= '0;
      else if (stb.incSub) subQ <= subQ + 1'b1;
      if (stb.clrRep)      repQ <= '0;
      else if (stb.incRep) repQ <= repQ + 1'b1;
      if (stb.loadGap)       tmrQ <= TMR_W'(gapArr[subQ]);
      else if (stb.loadIdle) tmrQ <= TMR_W'(idleArr[subQ]);
      else if (stb.loadWait) tmrQ <= TMR_W'(waitQ);
      else if (stb.decTimer) tmrQ <= tmrQ - 1'b1;
    end
  end

  assign curReps  = repsArr[subQ];
  assign repLimit = (curReps == '0) ? '0 : curReps - 1'b1;

  always_comb begin
    flags           = '0;
    flags.repLast   = (repQ == repLimit);
    flags.gapZero   = (gapArr[subQ] == '0);
    flags.idleZero  = (idleArr[subQ] == '0);
    flags.waitZero  = (waitQ == '0);
    flags.timerOne  = (tmrQ == TMR_W'(1));
    flags.subLast   = (subQ == lastQ);
    flags.iterOne   = (iterQ == ITER_W'(1));
    flags.iterZero  = (iterQ == '0);
    flags.iterInf   = (iterQ == '1);
    flags.startReq  = wrSeq && (wrIter != '0);
    flags.abortReq  = wrSeq && (wrIter == '0);
    flags.stopOnErr = stopQ;
    flags.trigEn    = trigEnQ;
  end

  assign subIdx  = subQ;
  assign cmdCode = codeArr[subQ];
  assign cmdAddr = addrArr[subQ];
  assign cmdDir  = dirArr[subQ];

  always_comb begin
    cfgRdData = '0;
    for (int i = 0; i < NUM_SUB; i++) begin
      if (cfgAddr == REG_AW'(CMD_BASE + i)) begin
        cfgRdData[ADDR_W-1:0]         = addrArr[i];
        cfgRdData[CODE_LSB +: CODE_W] = codeArr[i];
        cfgRdData[DIR_LSB +: DIR_W]   = dirArr[i];
      end
      if (cfgAddr == REG_AW'(TIM_BASE + i)) begin
        cfgRdData[REP_W-1:0]          = repsArr[i];
        cfgRdData[IDLE_LSB +: IDLE_W] = idleArr[i];
        cfgRdData[GAP_LSB +: GAP_W]   = gapArr[i];
      end
    end
    if (cfgAddr == REG_AW'(SEQ_ADDR)) begin
      cfgRdData[LAST_LSB +: SUB_W]  = lastQ;
      cfgRdData[STOP_BIT]           = stopQ;
      cfgRdData[TRIGEN_BIT]         = trigEnQ;
      cfgRdData[ITER_LSB +: ITER_W] = iterQ;
      cfgRdData[WAIT_LSB +: WAIT_W] = waitQ;
    end
    if (cfgAddr == REG_AW'(STAT_ADDR)) cfgRdData[STAT_W-1:0] = statusBits;
  end

  // endless count survives every pass unless software rewrites it
  assert_iter_hold_inf_R9: assert property (@(posedge clk) disable iff (!rstN)
    (iterQ == '1 && !wrSeq) |=> (iterQ == '1));
  // sub-sequences advance one index at a time
  assert_sub_order_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incSub && !stb.clrSub) |=> (subQ == $past(subQ) + 1'b1));
endmodule

// File: rtl/tcs_control.sv
module tcs_control
  import tcs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dp_flag_t    flags,
  input  logic        errIn,
  output ctl_strobe_t stb,
  output logic        cmdValid,
  output logic        seqIdle,
  output logic        seqBusy,
  output logic        seqDone,
  output logic        seqError,
  output logic        errTrigger
);
  seq_state_t stQ, stNext;
  logic doneQ, errQ, trigQ;
  logic busy, abortNow, stopNow, advance, startNow, doneSet, errSet;

  assign busy     = (stQ != ST_IDLE);
  assign abortNow = busy && flags.abortReq;
  assign stopNow  = busy && errIn && flags.stopOnErr;

  always_comb begin
    stb      = '0;
    stNext   = stQ;
    advance  = 1'b0;
    startNow = 1'b0;
    doneSet  = 1'b0;
    errSet   = 1'b0;
    if (abortNow) begin
      stNext = ST_IDLE;
    end else if (stopNow) begin
      stNext = ST_IDLE;
      errSet = 1'b1;
    end else begin
      case (stQ)
        ST_IDLE: if (flags.startReq) begin
          stNext     = ST_ISSUE;
          stb.clrSub = 1'b1;
          stb.clrRep = 1'b1;
          startNow   = 1'b1;
        end
        ST_ISSUE: if (!flags.repLast) begin
          stb.incRep = 1'b1;
          if (!flags.gapZero) begin
            stb.loadGap = 1'b1;
            stNext      = ST_GAP;
          end
        end else begin
          stb.clrRep = 1'b1;
          if (!flags.idleZero) begin
            stb.loadIdle = 1'b1;
            stNext       = ST_POST;
          end else begin
            advance = 1'b1;
          end
        end
        ST_GAP:  if (flags.timerOne) stNext = ST_ISSUE; else stb.decTimer = 1'b1;
        ST_POST: if (flags.timerOne) advance = 1'b1;    else stb.decTimer = 1'b1;
        ST_WAIT: if (flags.timerOne) begin
          if (flags.iterZero) begin
            stNext  = ST_IDLE;
            doneSet = 1'b1;
          end else begin
            stNext = ST_ISSUE;
          end
        end else begin
          stb.decTimer = 1'b1;
        end
        default: stNext = ST_IDLE;
      endcase
      if (advance) begin
        if (!flags.subLast) begin
          stb.incSub = 1'b1;
          stNext     = ST_ISSUE;
        end else begin
          stb.clrSub  = 1'b1;
          stb.decIter = 1'b1;
          if (!flags.waitZero) begin
            stb.loadWait = 1'b1;
            stNext       = ST_WAIT;
          end else if (!flags.iterInf && flags.iterOne) begin
            stNext  = ST_IDLE;
            doneSet = 1'b1;
          end else begin
            stNext = ST_ISSUE;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ   <= ST_IDLE;
      doneQ <= 1'b0;
      errQ  <= 1'b0;
      trigQ <= 1'b0;
    end else begin
      stQ <= stNext;
      if (startNow) begin
        doneQ <= 1'b0;
        errQ  <= 1'b0;
        trigQ <= 1'b0;
      end else begin
        if (doneSet) doneQ <= 1'b1;
        if (errSet)  errQ  <= 1'b1;
        if (busy && errIn && flags.trigEn) trigQ <= 1'b1;
      end
    end
  end

  assign cmdValid   = (stQ == ST_ISSUE);
  assign seqIdle    = !busy;
  assign seqBusy    = busy;
  assign seqDone    = doneQ;
  assign seqError   = errQ;
  assign errTrigger = trigQ;

  assert_start_issue_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_IDLE && flags.startReq) |=> (cmdValid && !doneQ && !errQ && !trigQ));
  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && flags.abortReq) |=> (stQ == ST_IDLE && !cmdValid && !doneQ));
  assert_stop_err_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && errIn && flags.stopOnErr && !flags.abortReq) |=> (stQ == ST_IDLE && errQ));
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> (stQ == ST_IDLE));
  assert_trig_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trigQ) |-> $past(errIn));
endmodule

// File: rtl/train_cmd_seq.sv
module train_cmd_seq
  import tcs_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [REG_AW-1:0]  cfgAddr,
  input  logic [DATA_W-1:0]  cfgWrData,
  output logic [DATA_W-1:0]  cfgRdData,
  input  logic               errIn,
  output logic               cmdValid,
  output logic [SUB_W-1:0]   cmdSubIdx,
  output logic [CODE_W-1:0]  cmdCode,
  output logic [ADDR_W-1:0]  cmdAddr,
  output logic [DIR_W-1:0]   cmdDir,
  output logic               seqIdle,
  output logic               seqBusy,
  output logic               seqDone,
  output logic               seqError,
  output logic               errTrigger
);
  ctl_strobe_t stb;
  dp_flag_t    flags;
  logic [STAT_W-1:0] statusBits;

  assign statusBits = {errTrigger, seqError, seqDone, seqBusy, seqIdle};

  tcs_datapath u_datapath (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .stb(stb),
    .statusBits(statusBits), .flags(flags), .subIdx(cmdSubIdx),
    .cmdCode(cmdCode), .cmdAddr(cmdAddr), .cmdDir(cmdDir)
  );

  tcs_control u_control (
    .clk(clk), .rstN(rstN), .flags(flags), .errIn(errIn), .stb(stb),
    .cmdValid(cmdValid), .seqIdle(seqIdle), .seqBusy(seqBusy),
    .seqDone(seqDone), .seqError(seqError), .errTrigger(errTrigger)
  );
endmodule

// File: tb/train_cmd_seq_bench.sv
module train_cmd_seq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        errIn = 1'b0;
  logic        cmdValid;
  logic [1:0]  cmdSubIdx;
  logic [2:0]  cmdCode;
  logic [15:0] cmdAddr;
  logic [1:0]  cmdDir;
  logic        seqIdle, seqBusy, seqDone, seqError, errTrigger;

  int nTests = 0;
  int nFail = 0;
  int cyc = 0;
  bit modelOn = 0;
  int logCyc[$];
  int logSub[$];

  always #10 clk = ~clk;

  train_cmd_seq u_train_cmd_seq (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .errIn(errIn),
    .cmdValid(cmdValid), .cmdSubIdx(cmdSubIdx), .cmdCode(cmdCode),
    .cmdAddr(cmdAddr), .cmdDir(cmdDir), .seqIdle(seqIdle), .seqBusy(seqBusy),
    .seqDone(seqDone), .seqError(seqError), .errTrigger(errTrigger)
  );

  task automatic check(string req, string what, longint act, longint exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mMode;            // 0 idle, 1 issuing, 2 gap, 3 post-idle, 4 pass rest
  int mSub, mCnt, mLeft, mIter, mWait, mLast;
  int mStop, mTrigEn, mDone, mErr, mTrig;
  int mReps[4], mGap[4], mIdl[4], mAd[4], mCo[4], mDi[4];

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mMode = 0; mSub = 0; mCnt = 0; mLeft = 0; mIter = 0; mWait = 0; mLast = 0;
      mStop = 0; mTrigEn = 0; mDone = 0; mErr = 0; mTrig = 0;
      for (int i = 0; i < 4; i++) begin
        mReps[i] = 0; mGap[i] = 0; mIdl[i] = 0; mAd[i] = 0; mCo[i] = 0; mDi[i] = 0;
      end
    end else begin
      automatic bit wSeq = cfgWrEn && cfgAddr == 8;
      automatic int wIter = cfgWrData[15:8];
      automatic bit nextPart = 0;
      automatic bit passEnd = 0;
      automatic int was = mMode;
      if (was != 0 && errIn && mTrigEn) mTrig = 1;
      if (was != 0 && wSeq && wIter == 0) mMode = 0;
      else if (was != 0 && errIn && mStop) begin mMode = 0; mErr = 1; end
      else if (was == 0) begin
        if (wSeq && wIter != 0) begin
          mMode = 1; mSub = 0; mCnt = 0; mDone = 0; mErr = 0; mTrig = 0;
        end
      end else if (was == 1) begin
        mCnt++;
        if (mCnt < ((mReps[mSub] == 0) ? 1 : mReps[mSub])) begin
          if (mGap[mSub] != 0) begin mMode = 2; mLeft = mGap[mSub]; end
        end else begin
          mCnt = 0;
          if (mIdl[mSub] != 0) begin mMode = 3; mLeft = mIdl[mSub]; end
          else nextPart = 1;
        end
      end else if (was == 2) begin
        if (mLeft == 1) mMode = 1; else mLeft--;
      end else if (was == 3) begin
        if (mLeft == 1) nextPart = 1; else mLeft--;
      end else begin
        if (mLeft == 1) begin
          if (mIter == 0) begin mMode = 0; mDone = 1; end else mMode = 1;
        end else mLeft--;
      end
      if (nextPart) begin
        if (mSub != mLast) begin mSub = (mSub + 1) % 4; mMode = 1; end
        else begin
          mSub = 0; passEnd = 1;
          if (mWait != 0) begin mMode = 4; mLeft = mWait; end
          else if (mIter == 1) begin mMode = 0; mDone = 1; end
          else mMode = 1;
        end
      end
      if (passEnd && mIter != 255 && mIter != 0) mIter--;
      if (cfgWrEn) begin
        if (cfgAddr < 4) begin
          mAd[cfgAddr] = cfgWrData[15:0]; mCo[cfgAddr] = cfgWrData[18:16];
          mDi[cfgAddr] = cfgWrData[21:20];
        end else if (cfgAddr < 8) begin
          mReps[cfgAddr-4] = cfgWrData[8:0]; mIdl[cfgAddr-4] = cfgWrData[17:9];
          mGap[cfgAddr-4] = cfgWrData[22:18];
        end else if (cfgAddr == 8) begin
          mLast = cfgWrData[1:0]; mStop = cfgWrData[2]; mTrigEn = cfgWrData[3];
          mIter = wIter; mWait = cfgWrData[24:16];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && modelOn) begin
      check("R3", "cmdValid", cmdValid, mMode == 1);
      if (mMode == 1) begin
        check("R6", "cmdSubIdx", cmdSubIdx, mSub);
        check("R3", "cmd fields", {cmdAddr, cmdCode, cmdDir},
              {mAd[mSub][15:0], mCo[mSub][2:0], mDi[mSub][1:0]});
      end
      check("R8", "idle/busy/done", {seqIdle, seqBusy, seqDone},
            {mMode == 0, mMode != 0, mDone[0]});
      check("R10", "error", seqError, mErr);
      check("R11", "trigger", errTrigger, mTrig);
    end
    if (cmdValid) begin logCyc.push_back(cyc); logSub.push_back(cmdSubIdx); end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a[3:0]; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    cfgAddr = a[3:0];
    #1 d = cfgRdData;
  endtask

  function automatic logic [31:0] cmdWord(int ad, int co, int di);
    return 32'(ad) | (32'(co) << 16) | (32'(di) << 20);
  endfunction
  function automatic logic [31:0] timWord(int reps, int idl, int gap);
    return 32'(reps) | (32'(idl) << 9) | (32'(gap) << 18);
  endfunction
  function automatic logic [31:0] seqWord(int last, int stop, int trg, int iter, int w);
    return 32'(last) | (32'(stop) << 2) | (32'(trg) << 3) | (32'(iter) << 8) | (32'(w) << 16);
  endfunction

  task automatic waitIdle();
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (seqIdle) break;
    end
  endtask

  task automatic clearLog();
    logCyc.delete(); logSub.delete();
  endtask

  initial begin
    automatic logic [31:0] rv;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "idle", seqIdle, 1);
    check("R1", "busy/done/err/trig", {seqBusy, seqDone, seqError, errTrigger}, 0);
    check("R1", "cmdValid", cmdValid, 0);
    rd(8, rv); check("R1", "seq reg", rv, 0);
    rd(5, rv); check("R1", "timing reg", rv, 0);
    rstN = 1'b1;
    @(negedge clk);
    modelOn = 1;

    // R3 R4: single sub-sequence, three issues with gap 2
    wr(0, cmdWord(16'h1234, 5, 1));
    wr(4, timWord(3, 0, 2));
    clearLog();
    wr(8, seqWord(0, 0, 0, 1, 0));
    waitIdle();
    check("R3", "issue count", logCyc.size(), 3);
    if (logCyc.size() == 3) begin
      check("R4", "spacing 1", logCyc[1] - logCyc[0], 3);
      check("R4", "spacing 2", logCyc[2] - logCyc[1], 3);
    end
    check("R8", "done", seqDone, 1);
    rd(8, rv); check("R7", "count after run", rv[15:8], 0);
    rd(9, rv); check("R12", "status word", rv, 32'h5);

    // R5 R6 R7: four subs, zero reps on sub 0, two passes with rest 4
    wr(1, cmdWord(16'h0100, 2, 2));
    wr(2, cmdWord(16'h0200, 3, 3));
    wr(3, cmdWord(16'h0300, 4, 0));
    wr(4, timWord(0, 2, 0));
    wr(5, timWord(2, 0, 1));
    wr(6, timWord(1, 3, 0));
    wr(7, timWord(3, 0, 0));
    clearLog();
    wr(8, seqWord(3, 0, 0, 2, 4));
    waitIdle();
    check("R6", "issue count", logSub.size(), 14);
    if (logSub.size() == 14) begin
      automatic int expSub[14] = '{0, 1, 1, 2, 3, 3, 3, 0, 1, 1, 2, 3, 3, 3};
      automatic int bad = 0;
      for (int k = 0; k < 14; k++) if (logSub[k] != expSub[k]) bad++;
      check("R6", "order mismatches", bad, 0);
      check("R3", "zero reps issues once", logSub[0] == 0 && logSub[1] == 1, 1);
      check("R5", "post idle spacing", logCyc[1] - logCyc[0], 3);
      check("R7", "pass rest spacing", logCyc[7] - logCyc[6], 5);
    end
    check("R8", "done after two passes", seqDone, 1);

    // R6: last index 1 limits to subs 0 and 1
    clearLog();
    wr(8, seqWord(1, 0, 0, 1, 0));
    waitIdle();
    check("R6", "issues with last=1", logSub.size(), 3);
    if (logSub.size() == 3) check("R6", "highest sub", logSub[2], 1);

    // R9: endless run then abort
    wr(4, timWord(2, 0, 3));
    wr(8, seqWord(0, 0, 0, 255, 0));
    repeat (40) @(negedge clk);
    rd(8, rv); check("R9", "endless count held", rv[15:8], 255);
    check("R9", "still busy", seqBusy, 1);
    wr(8, seqWord(0, 0, 0, 0, 0));
    clearLog();
    repeat (10) @(negedge clk);
    check("R9", "no issue after abort", logCyc.size(), 0);
    check("R9", "idle, not done", {seqIdle, seqDone}, 2'b10);

    // R10 R11: stop on error inside a gap
    wr(4, timWord(20, 0, 2));
    wr(8, seqWord(0, 1, 1, 1, 0));
    repeat (5) @(negedge clk);
    errIn = 1'b1;
    @(negedge clk);
    errIn = 1'b0;
    check("R10", "idle after error", seqIdle, 1);
    check("R10", "error flag", seqError, 1);
    check("R11", "trigger flag", errTrigger, 1);
    clearLog();
    repeat (10) @(negedge clk);
    check("R10", "no issue after stop", logCyc.size(), 0);
    check("R10", "not done", seqDone, 0);

    // R11: trigger without stop, run completes
    wr(4, timWord(4, 0, 1));
    clearLog();
    wr(8, seqWord(0, 0, 1, 1, 0));
    repeat (3) @(negedge clk);
    errIn = 1'b1;
    @(negedge clk);
    errIn = 1'b0;
    waitIdle();
    check("R11", "all issues sent", logCyc.size(), 4);
    check("R11", "done/err/trig", {seqDone, seqError, errTrigger}, 3'b101);

    // R2: restart clears flags and issues sub 0 next cycle
    wr(8, seqWord(0, 0, 0, 1, 0));
    check("R2", "first issue", {cmdValid, cmdSubIdx}, 3'b100);
    check("R2", "flags cleared", {seqDone, seqError, errTrigger}, 0);
    waitIdle();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    nTests++; nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule